// File: doc/BRIEF.md
# Branch-and-Link Next-PC and Writeback Unit

This block is the program-counter and register-file slice of a single-cycle 32-bit core. It holds the PC and a 32 x 32-bit register file. Each cycle it takes decoded control lines, register fields, a sign-extended branch offset, a 26-bit jump index and the ALU/memory result. From these it picks the next PC and decides what is written back.

A conditional branch-and-link is taken when its control line is high and the first operand is not negative, meaning bit 31 is clear. That gated term is merged into the ordinary branch select. The same term redirects the write to the link register, index 31, and sets the write data to PC+4. The unconditional jump-and-link always links and always jumps. Register reads are combinational. The register write and the PC update share one rising clock edge.

Top module: `link_branch_unit`

## Requirements
- R1: While `rst_ni` is low, the PC and every register are cleared, so after reset `pc_o` is 0 and every register reads 0.
- R2: With no branch or jump line high, the PC advances by 4 on each rising edge.
- R3: With `beq_i` high, the next PC is PC+4+(offset<<2) when the two read values are equal, and PC+4 when they differ.
- R4: With `bgezal_i` high and bit 31 of `rs_data_o` clear (zero included), the next PC is PC+4+(offset<<2) and register 31 receives the old PC+4.
- R5: With `bgezal_i` high and bit 31 of `rs_data_o` set, the next PC is PC+4 and no register is written, even when `reg_we_i` is high.
- R6: With `jal_i` high, the next PC is {PC+4 bits 31..28, `jidx_i`, 2'b00}, and register 31 receives PC+4 whatever `reg_we_i` is.
- R7: With `reg_we_i` high and no link taken, `result_i` is written to register `rd_addr_i` at the edge, and both read ports reflect it combinationally.
- R8: Register 0 reads as zero and ignores writes.
- R9: A negative sign-extended offset gives a backward branch target, PC+4 minus the scaled magnitude.
- R10: During a taken link, `rd_addr_i` and `result_i` have no effect, and the register named by `rd_addr_i` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| beq_i | input | 1 | Branch-if-equal decoded |
| bgezal_i | input | 1 | Branch-if-nonnegative-and-link decoded |
| jal_i | input | 1 | Jump-and-link decoded |
| reg_we_i | input | 1 | Normal register write enable |
| rs_addr_i | input | 5 | First read register index |
| rt_addr_i | input | 5 | Second read register index |
| rd_addr_i | input | 5 | Destination register index |
| br_off_i | input | 32 | Sign-extended branch offset in words |
| jidx_i | input | 26 | Jump word index |
| result_i | input | 32 | ALU/memory result for writeback |
| rs_data_o | output | 32 | First read value |
| rt_data_o | output | 32 | Second read value |
| pc_o | output | 32 | Current PC |

## Verification
The bench goes after the sign test at its edges. A zero operand must take the link branch, and a value with only bit 31 set must not. A design that tested strict positivity, or the wrong bit, would mis-steer the PC on one of these. Not-taken link branches are issued with `reg_we_i` high and with a live destination. A unit that leaked the normal write enable would corrupt that register, and one that linked anyway would overwrite register 31. Jump-and-link is also issued with `reg_we_i` low, which exposes a missing forced enable. Backward offsets and writes aimed at register 0 expose unsigned offset handling and a writable zero register.

// File: rtl/lbu_pkg.sv
package lbu_pkg;
  typedef struct packed {
    logic beq;
    logic bal;
    logic jal;
    logic we;
  } lbu_ctrl_t;

  typedef enum logic [1:0] {
    NPC_SEQ = 2'd0,
    NPC_BR  = 2'd1,
    NPC_JMP = 2'd2
  } npc_sel_e;
endpackage

// File: rtl/lbu_wb_steer.sv
module lbu_wb_steer
  import lbu_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned NREG = 32,
  parameter int unsigned AW   = $clog2(NREG)
) (
  input  lbu_ctrl_t       ctrl_i,
  input  logic            rs_neg_i,
  input  logic            regs_eq_i,
  input  logic [AW-1:0]   rd_addr_i,
  input  logic [XLEN-1:0] result_i,
  input  logic [XLEN-1:0] pc4_i,
  output npc_sel_e        npc_sel_o,
  output logic            we_o,
  output logic [AW-1:0]   waddr_o,
  output logic [XLEN-1:0] wdata_o
);
  localparam int unsigned LINK_REG = NREG - 1;

  logic bal_take, link, br_sel;

  always_comb begin
    bal_take = ctrl_i.bal & ~rs_neg_i;
    link     = bal_take | ctrl_i.jal;
    br_sel   = (ctrl_i.beq & regs_eq_i) | bal_take;
    if (ctrl_i.jal)  npc_sel_o = NPC_JMP;
    else if (br_sel) npc_sel_o = NPC_BR;
    else             npc_sel_o = NPC_SEQ;
    // a not-taken bgezal suppresses any normal write
    we_o    = link | (ctrl_i.we & ~ctrl_i.bal);
    waddr_o = link ? AW'(LINK_REG) : rd_addr_i;
    wdata_o = link ? pc4_i : result_i;
  end
endmodule

// File: rtl/lbu_pc_seq.sv
module lbu_pc_seq
  import lbu_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned JIDXW = 26
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  npc_sel_e         npc_sel_i,
  input  logic [XLEN-1:0]  br_off_i,
  input  logic [JIDXW-1:0] jidx_i,
  output logic [XLEN-1:0]  pc_o,
  output logic [XLEN-1:0]  pc4_o
);
  localparam int unsigned HIW = XLEN - JIDXW - 2;

  logic [XLEN-1:0] pc_q, pc_d, br_tgt, jmp_tgt;

  always_comb begin
    pc4_o   = pc_q + XLEN'(4);
    br_tgt  = pc4_o + {br_off_i[XLEN-3:0], 2'b00};
    jmp_tgt = {pc4_o[XLEN-1 -: HIW], jidx_i, 2'b00};
    unique case (npc_sel_i)
      NPC_BR:  pc_d = br_tgt;
      NPC_JMP: pc_d = jmp_tgt;
      default: pc_d = pc4_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  assign pc_o = pc_q;

  p_pc_reset_r1: assert property (@(posedge clk_i) $rose(rst_ni) |-> pc_q == '0);
  p_seq_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (npc_sel_i == NPC_SEQ) |=> pc_q == $past(pc_q) + XLEN'(4));
endmodule

// File: rtl/lbu_regfile.sv
module lbu_regfile #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned NREG = 32,
  parameter int unsigned AW   = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [AW-1:0]   waddr_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [AW-1:0]   raddr_a_i,
  input  logic [AW-1:0]   raddr_b_i,
  output logic [XLEN-1:0] rdata_a_o,
  output logic [XLEN-1:0] rdata_b_o
);
  logic [XLEN-1:0] rf_q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == 0) begin : g_zero
      assign rf_q[i] = '0;
    end else begin : g_ff
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                          rf_q[i] <= '0;
        else if (we_i && waddr_i == AW'(i)) rf_q[i] <= wdata_i;
      end
    end
  end

  assign rdata_a_o = rf_q[raddr_a_i];
  assign rdata_b_o = rf_q[raddr_b_i];

  p_write_lands_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && waddr_i != '0) |=> rf_q[$past(waddr_i)] == $past(wdata_i));
  p_zero_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raddr_a_i == '0) |-> rdata_a_o == '0);
endmodule

// File: rtl/link_branch_unit.sv
module link_branch_unit
  import lbu_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned NREG  = 32,
  parameter int unsigned AW    = $clog2(NREG),
  parameter int unsigned JIDXW = 26
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             beq_i,
  input  logic             bgezal_i,
  input  logic             jal_i,
  input  logic             reg_we_i,
  input  logic [AW-1:0]    rs_addr_i,
  input  logic [AW-1:0]    rt_addr_i,
  input  logic [AW-1:0]    rd_addr_i,
  input  logic [XLEN-1:0]  br_off_i,
  input  logic [JIDXW-1:0] jidx_i,
  input  logic [XLEN-1:0]  result_i,
  output logic [XLEN-1:0]  rs_data_o,
  output logic [XLEN-1:0]  rt_data_o,
  output logic [XLEN-1:0]  pc_o
);
  lbu_ctrl_t       ctrl;
  npc_sel_e        npc_sel;
  logic            we;
  logic [AW-1:0]   waddr;
  logic [XLEN-1:0] wdata, pc4;

  assign ctrl = '{beq: beq_i, bal: bgezal_i, jal: jal_i, we: reg_we_i};

  lbu_regfile #(.XLEN(XLEN), .NREG(NREG), .AW(AW)) u_rf (
    .clk_i, .rst_ni,
    .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
    .raddr_a_i(rs_addr_i), .raddr_b_i(rt_addr_i),
    .rdata_a_o(rs_data_o), .rdata_b_o(rt_data_o)
  );

  lbu_wb_steer #(.XLEN(XLEN), .NREG(NREG), .AW(AW)) u_steer (
    .ctrl_i(ctrl), .rs_neg_i(rs_data_o[XLEN-1]),
    .regs_eq_i(rs_data_o == rt_data_o),
    .rd_addr_i, .result_i, .pc4_i(pc4),
    .npc_sel_o(npc_sel), .we_o(we), .waddr_o(waddr), .wdata_o(wdata)
  );

  lbu_pc_seq #(.XLEN(XLEN), .JIDXW(JIDXW)) u_pc (
    .clk_i, .rst_ni, .npc_sel_i(npc_sel),
    .br_off_i, .jidx_i, .pc_o, .pc4_o(pc4)
  );

  p_beq_taken_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beq_i && !jal_i && !bgezal_i && rs_data_o == rt_data_o)
    |=> pc_o == $past(pc_o) + XLEN'(4) + ($past(br_off_i) << 2));
  p_bal_taken_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bgezal_i && !jal_i && !rs_data_o[XLEN-1])
    |=> pc_o == $past(pc_o) + XLEN'(4) + ($past(br_off_i) << 2));
  p_bal_skip_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bgezal_i && !jal_i && !beq_i && rs_data_o[XLEN-1])
    |=> pc_o == $past(pc_o) + XLEN'(4));
  p_jal_target_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jal_i |=> (pc_o[1:0] == 2'b00) && (pc_o[JIDXW+1:2] == $past(jidx_i)));
endmodule

// File: tb/link_branch_unit_tb_top.sv
module link_branch_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        beq_i = 0, bgezal_i = 0, jal_i = 0, reg_we_i = 0;
  logic [4:0]  rs_addr_i = 0, rt_addr_i = 0, rd_addr_i = 0;
  logic [31:0] br_off_i = 0, result_i = 0;
  logic [25:0] jidx_i = 0;
  logic [31:0] rs_data_o, rt_data_o, pc_o;

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_pc = 0;
  logic done = 0;

  always #5 clk_i = ~clk_i;

  link_branch_unit dut_i (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic idle();
    beq_i = 0; bgezal_i = 0; jal_i = 0; reg_we_i = 0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [4:0] b);
    rs_addr_i = a; rt_addr_i = b; #1;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] v);
    reg_we_i = 1; rd_addr_i = a; result_i = v;
    cyc(); idle(); exp_pc += 4;
  endtask

  task automatic t_reset();
    rd(5'd31, 5'd5);
    chk("R1 pc", pc_o, 32'h0);
    chk("R1 r31", rs_data_o, 32'h0);
    chk("R1 r5", rt_data_o, 32'h0);
  endtask

  task automatic t_seq();
    for (int i = 0; i < 3; i++) begin
      cyc(); exp_pc += 4;
      chk("R2 step", pc_o, exp_pc);
    end
  endtask

  task automatic t_regs();
    wr(5'd5, 32'h1234_5678);
    wr(5'd6, 32'h1234_5678);
    wr(5'd7, 32'h8000_0000);
    rd(5'd5, 5'd7);
    chk("R7 read a", rs_data_o, 32'h1234_5678);
    chk("R7 read b", rt_data_o, 32'h8000_0000);
    wr(5'd0, 32'hDEAD_BEEF);
    rd(5'd0, 5'd6);
    chk("R8 zero", rs_data_o, 32'h0);
    chk("R7 pc", pc_o, exp_pc);
  endtask

  task automatic t_beq();
    rd(5'd5, 5'd6); beq_i = 1; br_off_i = 32'd8;
    cyc(); idle(); exp_pc = exp_pc + 4 + 32;
    chk("R3 taken", pc_o, exp_pc);
    rd(5'd5, 5'd7); beq_i = 1;
    cyc(); idle(); exp_pc += 4;
    chk("R3 not taken", pc_o, exp_pc);
    rd(5'd5, 5'd6); beq_i = 1; br_off_i = 32'hFFFF_FFFD;
    cyc(); idle(); exp_pc = exp_pc + 4 - 12;
    chk("R9 backward", pc_o, exp_pc);
  endtask

  task automatic t_bal_taken();
    logic [31:0] link;
    // zero operand counts as non-negative
    rd(5'd0, 5'd5); bgezal_i = 1; br_off_i = 32'd16;
    reg_we_i = 1; rd_addr_i = 5'd5; result_i = 32'hAAAA_AAAA;
    link = exp_pc + 4;
    cyc(); idle(); exp_pc = link + 64;
    chk("R4 zero pc", pc_o, exp_pc);
    rd(5'd31, 5'd5);
    chk("R4 link", rs_data_o, link);
    chk("R10 rd kept", rt_data_o, 32'h1234_5678);
    rd(5'd5, 5'd0); bgezal_i = 1; br_off_i = 32'hFFFF_FFFF;
    link = exp_pc + 4;
    cyc(); idle(); exp_pc = link - 4;
    chk("R4 pos pc", pc_o, exp_pc);
    rd(5'd31, 5'd0);
    chk("R4 pos link", rs_data_o, link);
  endtask

  task automatic t_bal_not();
    logic [31:0] old31;
    rd(5'd31, 5'd0); old31 = rs_data_o;
    rd(5'd7, 5'd6); bgezal_i = 1; br_off_i = 32'd100;
    reg_we_i = 1; rd_addr_i = 5'd6; result_i = 32'h0000_0055;
    cyc(); idle(); exp_pc += 4;
    chk("R5 pc", pc_o, exp_pc);
    rd(5'd31, 5'd6);
    chk("R5 r31 kept", rs_data_o, old31);
    chk("R5 rd kept", rt_data_o, 32'h1234_5678);
  endtask

  task automatic t_jal();
    logic [31:0] link;
    jal_i = 1; jidx_i = 26'h0AB_CDEF; reg_we_i = 0;
    rd_addr_i = 5'd5; result_i = 32'h5555_0000;
    link = exp_pc + 4;
    cyc(); idle();
    exp_pc = {link[31:28], 26'h0AB_CDEF, 2'b00};
    chk("R6 pc", pc_o, exp_pc);
    rd(5'd31, 5'd5);
    chk("R6 link", rs_data_o, link);
    chk("R10 jal rd kept", rt_data_o, 32'h1234_5678);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    t_reset();
    t_seq();
    t_regs();
    t_beq();
    t_bal_taken();
    t_bal_not();
    t_jal();
    t_seq();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule